// File: doc/BRIEF.md
# Circular Sample Capture Controller

This block stores a stream of 64-bit sample words into a ring inside a private synchronous RAM. A rising edge on the enable input arms it. From then on, every sample it keeps is written at the next slot of a region set by a start word and a size in words. After the last slot of the region, writing continues at the start word and a wrap flag is raised. A one-cycle trigger pulse from an external detector starts a post-trigger timer. Capture goes on for that time and then stops. The busy output falls at that point, so software polling it knows the buffer is stable.

Software then reads the ring back through a paged window. It uses the wrap flag and the finish address, given in 8-byte units, to put the samples back in time order. With the wrap flag set, the oldest sample sits one slot after the finish address and the whole region is valid. With it clear, the valid samples run from the start word up to the finish address.

The post-trigger time is requested in microseconds and held internally as a 7-bit count of power-of-two units. A microsecond tick derived from the `CLK_MHZ` parameter drives the timer. A 3-bit rate code thins the incoming stream before storage.

Top module: `sample_ring_capture`

## Requirements
- R1: While `rst_n` is low, `busy`, `wrap` and `fin_addr` are 0.
- R2: A low-to-high change of `en` seen at a clock edge sets the following state one cycle later: `busy` is 1, `wrap` is 0 and `fin_addr` equals `cfg_start`. Samples seen at that edge, and any seen earlier, are not stored.
- R3: Each stored sample goes to the current write slot, which begins at `cfg_start`. After a store, `fin_addr` is the index, in 8-byte words, of the slot just written.
- R4: After slot `cfg_start+cfg_size-1` is written, the next slot is `cfg_start` and `wrap` becomes 1. `wrap` then stays 1 until the next arm.
- R5: Rate code c in 0..6 stores the first of every 2^(c+1) valid samples, counted from the arm (output rate 80>>c MHz of a 160 MHz stream). Code 7 stores every valid sample.
- R6: A requested time u of 0..8191 µs is encoded with the smallest exponent e in 0..6 for which u < 128·2^e, and a count of u>>e. The time actually applied is D = (u>>e)·2^e µs.
- R7: A trigger is accepted at the first edge where `trig` is 1 while busy and not yet triggered. `busy` stays 1 for D·CLK_MHZ+1 further edges, and valid samples at those edges are still stored. Later trigger pulses in the same capture have no effect.
- R8: A trigger while not busy has no effect: `busy` stays 0.
- R9: Once capture has ended, valid samples are ignored. `fin_addr` and `wrap` hold until `en` falls and rises again.
- R10: If `en` falls during a capture, `busy` clears at the next edge and no further samples are stored.
- R11: Readback uses `rd_page` (byte address / 4096) and `rd_woff` (32-bit word offset inside the page). The slot is page·512 + rd_woff[9:1]. `rd_woff[0]`=1 returns bits 63:32 and 0 returns bits 31:0, one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Arm level; a rising edge starts a capture |
| smp_data | input | 64 | Sample word |
| smp_vld | input | 1 | Sample valid strobe |
| trig | input | 1 | Trigger pulse from the detector |
| cfg_start | input | AW | First slot of the ring, in 8-byte words |
| cfg_size | input | AW+1 | Ring length in words (start+size ≤ RAM_WORDS) |
| cfg_rate | input | 3 | Sample rate code |
| cfg_post_us | input | 13 | Requested post-trigger time in µs |
| busy | output | 1 | Capture in progress (poll bit) |
| wrap | output | 1 | Ring has wrapped at least once |
| fin_addr | output | FIN_W | Last written slot, in 8-byte words |
| rd_page | input | AW-9 | Readback page select |
| rd_woff | input | 10 | 32-bit word offset inside the page |
| rd_data | output | 32 | Readback word |

## Verification
The bench attacks the end of the post-trigger window, including a zero-length window. A design off by one there would keep or drop one sample and shift `fin_addr`, and the per-cycle comparison catches that. Rings are run both short enough to wrap several times and long enough not to wrap. A wrong end-slot compare or a missing wrap flag would then leave stale slots or wrong order on readback. Retriggers, triggers while idle, samples after completion and an abort by dropping `en` are all driven. Any of them changing state would move `busy` or `fin_addr` away from the model. Time requests at exponent boundaries and a value that truncates (301 µs) check the encoding, since a design that skipped it would run 1 µs long.

// File: rtl/sample_ring_capture.sv
module sample_ring_capture #(
  parameter int CLK_MHZ   = 4,
  parameter int RAM_WORDS = 1024,
  parameter int FIN_W     = 15,
  localparam int AW       = $clog2(RAM_WORDS),
  localparam int PAGE_W   = AW - 9,
  localparam int DW       = $clog2(CLK_MHZ) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [63:0]       smp_data,
  input  logic              smp_vld,
  input  logic              trig,
  input  logic [AW-1:0]     cfg_start,
  input  logic [AW:0]       cfg_size,
  input  logic [2:0]        cfg_rate,
  input  logic [12:0]       cfg_post_us,
  output logic              busy,
  output logic              wrap,
  output logic [FIN_W-1:0]  fin_addr,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [9:0]        rd_woff,
  output logic [31:0]       rd_data
);

  logic [63:0]   mem [RAM_WORDS];
  logic [63:0]   rd_word;
  logic          hi_q;
  logic          en_q, trig_seen;
  logic [AW-1:0] wp, fin;
  logic [6:0]    dcnt;
  logic [DW-1:0] div;
  logic [12:0]   us_cnt, tgt;

  logic [2:0]  t_exp;
  logic [6:0]  t_cnt;
  logic [12:0] t_us;

  always_comb begin
    t_exp = 3'd6;
    for (int e = 6; e >= 0; e--)
      if ({1'b0, cfg_post_us} < (14'd128 << e)) t_exp = 3'(e);
  end
  assign t_cnt = 7'(cfg_post_us >> t_exp);
  assign t_us  = 13'({6'd0, t_cnt} << t_exp);

  logic [6:0] kmask;
  assign kmask = (cfg_rate == 3'd7) ? 7'd0 : 7'((8'd2 << cfg_rate) - 8'd1);

  logic [AW:0] end_x;
  logic        start_p, keep, we, at_end, tick, done;
  assign end_x   = {1'b0, cfg_start} + cfg_size - 1'b1;
  assign start_p = en & ~en_q;
  assign keep    = (dcnt & kmask) == 7'd0;
  assign we      = busy & en & smp_vld & keep;
  assign at_end  = (wp == end_x[AW-1:0]);
  assign tick    = trig_seen && (div == DW'(CLK_MHZ - 1));
  assign done    = trig_seen && (us_cnt == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; busy <= 1'b0; wrap <= 1'b0; trig_seen <= 1'b0;
      wp <= '0; fin <= '0; dcnt <= '0; div <= '0; us_cnt <= '0; tgt <= '0;
    end else begin
      en_q <= en;
      if (start_p) begin
        busy <= 1'b1; wrap <= 1'b0; trig_seen <= 1'b0;
        wp <= cfg_start; fin <= cfg_start;
        dcnt <= '0; div <= '0; us_cnt <= '0; tgt <= t_us;
      end else if (busy) begin
        if (!en) begin
          busy <= 1'b0; trig_seen <= 1'b0;
        end else begin
          if (smp_vld) dcnt <= dcnt + 1'b1;
          if (we) begin
            fin <= wp;
            wp  <= at_end ? cfg_start : wp + 1'b1;
            if (at_end) wrap <= 1'b1;
          end
          if (trig_seen) begin
            if (done) begin
              busy <= 1'b0; trig_seen <= 1'b0;
            end else if (tick) begin
              div <= '0; us_cnt <= us_cnt + 1'b1;
            end else begin
              div <= div + 1'b1;
            end
          end else if (trig) begin
            trig_seen <= 1'b1; div <= '0; us_cnt <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wp] <= smp_data;
    rd_word <= mem[{rd_page, rd_woff[9:1]}];
    hi_q    <= rd_woff[0];
  end

  assign rd_data  = hi_q ? rd_word[63:32] : rd_word[31:0];
  assign fin_addr = FIN_W'(fin);

  AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n) (en && !en_q) |=> busy && !wrap && fin_addr == FIN_W'($past(cfg_start))); // R2
  AST_WP_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (wp >= cfg_start) && ({1'b0, wp} <= end_x)); // R4
  AST_WRAP_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n) $rose(wrap) |-> $past(busy) && $past(smp_vld)); // R4
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !(en && !en_q)) |=> $stable(fin_addr) && $stable(wrap)); // R9
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n) trig_seen |-> us_cnt <= tgt); // R7
  AST_BUSY_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(trig_seen) || !$past(en)); // R7
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (busy && !en) |=> !busy); // R10

endmodule

// File: tb/sim_sample_ring_capture.sv
module sim_sample_ring_capture;
  localparam int CLK_PER = 10;
  localparam int M  = 4;
  localparam int RW = 1024;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, en = 0, smp_vld = 0, trig = 0;
  logic [63:0] smp_data = '0;
  logic [AW-1:0] cfg_start = '0;
  logic [AW:0] cfg_size = 11'd8;
  logic [2:0] cfg_rate = '0;
  logic [12:0] cfg_post_us = '0;
  logic busy, wrap;
  logic [14:0] fin_addr;
  logic [0:0] rd_page = '0;
  logic [9:0] rd_woff = '0;
  logic [31:0] rd_data;

  sample_ring_capture #(.CLK_MHZ(M), .RAM_WORDS(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_data(smp_data), .smp_vld(smp_vld),
    .trig(trig), .cfg_start(cfg_start), .cfg_size(cfg_size), .cfg_rate(cfg_rate),
    .cfg_post_us(cfg_post_us), .busy(busy), .wrap(wrap), .fin_addr(fin_addr),
    .rd_page(rd_page), .rd_woff(rd_woff), .rd_data(rd_data));

  always #(CLK_PER/2) clk = ~clk;

  int nchk = 0, nerr = 0, cycles = 0, vld_period = 0, gen = 0;
  bit [63:0] mmem [RW];
  bit        mwr  [RW];
  int mbusy = 0, mwrap = 0, mfin = 0, mwp = 0, mtrig = 0, mleft = 0, mvcnt = 0, mD = 0, menq = 0;

  function automatic int enc_us(int us);
    int e = 0;
    while (us >= (128 << e)) e++;
    return (us >> e) << e;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mwrap = 0; mfin = 0; mwp = 0; mtrig = 0; menq = 0;
    end else begin
      if (en && !menq) begin
        mbusy = 1; mwrap = 0; mfin = int'(cfg_start); mwp = int'(cfg_start);
        mtrig = 0; mvcnt = 0; mD = enc_us(int'(cfg_post_us));
      end else if (mbusy != 0) begin
        if (!en) mbusy = 0;
        else begin
          if (smp_vld) begin
            if (cfg_rate == 3'd7 || (mvcnt % (2 << int'(cfg_rate))) == 0) begin
              mmem[mwp] = smp_data; mwr[mwp] = 1; mfin = mwp;
              if (mwp == int'(cfg_start) + int'(cfg_size) - 1) begin mwp = int'(cfg_start); mwrap = 1; end
              else mwp++;
            end
            mvcnt++;
          end
          if (mtrig != 0) begin
            mleft--;
            if (mleft == 0) mbusy = 0;
          end else if (trig) begin
            mtrig = 1; mleft = mD * M + 1;
          end
        end
      end
      menq = int'(en);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == mbusy[0], "R7 busy vs model", busy, mbusy);
      check(wrap == mwrap[0], "R4 wrap vs model", wrap, mwrap);
      check(int'(fin_addr) == mfin, "R3 fin_addr vs model", fin_addr, mfin);
    end
    gen++;
    smp_vld <= (vld_period > 0) && (gen % vld_period == 0);
    smp_data <= {32'(gen * 7 + 3), ~32'(gen)};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input int st, input int sz, input int rate, input int us, input int vp);
    en = 0; cyc(2);
    cfg_start = AW'(st); cfg_size = 11'(sz); cfg_rate = 3'(rate); cfg_post_us = 13'(us);
    vld_period = vp;
    en = 1; cyc(1);
    check(busy == 1 && wrap == 0, "R2 armed busy and wrap", {busy, wrap}, 2'b10);
    check(int'(fin_addr) == st, "R2 fin at start", fin_addr, st);
  endtask

  task automatic trig_measure(input int us, input bit retrig, input string tag);
    int cnt = 0;
    trig = 1; cyc(1); trig = 0;
    while (busy && cnt < 40000) begin
      cnt++;
      if (retrig && cnt == 3) trig = 1;
      if (retrig && cnt == 4) trig = 0;
      cyc(1);
    end
    trig = 0;
    check(cnt == enc_us(us) * M + 1, tag, cnt, enc_us(us) * M + 1);
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < RW; i++) begin
      if (mwr[i]) begin
        rd_page = 1'(i >> 9); rd_woff = 10'((i & 511) << 1); cyc(1);
        check(rd_data == mmem[i][31:0], tag, rd_data, mmem[i][31:0]);
        rd_woff = 10'(((i & 511) << 1) | 1); cyc(1);
        check(rd_data == mmem[i][63:32], tag, rd_data, mmem[i][63:32]);
      end
    end
  endtask

  task automatic hold_check(input string tag);
    logic [14:0] f0; logic w0;
    f0 = fin_addr; w0 = wrap;
    cyc(20);
    check(fin_addr == f0 && wrap == w0, tag, fin_addr, f0);
  endtask

  initial begin
    cyc(3);
    check(busy == 0 && wrap == 0 && fin_addr == 0, "R1 reset state", {busy, wrap, fin_addr}, 0);
    rst_n = 1; cyc(2);
    trig = 1; cyc(1); trig = 0; cyc(2);
    check(busy == 0, "R8 idle trigger ignored", busy, 0);

    arm(16, 20, 7, 2, 1);
    cyc(30);
    trig_measure(2, 1, "R7 window with retrigger");
    check(wrap == 1, "R4 ring wrapped", wrap, 1);
    hold_check("R9 samples after completion ignored");
    readback("R11 readback short ring");

    arm(600, 100, 0, 301, 8);
    cyc(40);
    trig_measure(301, 0, "R6 truncated time 301us");
    check(wrap == 0, "R4 no wrap on long ring", wrap, 0);
    readback("R5 readback rate code 0 page 1");

    arm(0, 8, 2, 0, 1);
    cyc(50);
    trig_measure(0, 0, "R7 zero length window");
    readback("R5 readback rate code 2");

    arm(100, 50, 7, 200, 1);
    cyc(10);
    trig = 1; cyc(1); trig = 0; cyc(5);
    en = 0; cyc(1);
    check(busy == 0, "R10 abort clears busy", busy, 0);
    hold_check("R10 no store after abort");
    en = 1; cyc(1);
    check(busy == 1 && int'(fin_addr) == 100 && wrap == 0, "R2 rearm resets pointer", fin_addr, 100);

    arm(0, 1024, 6, 8191, 1);
    cyc(20);
    trig_measure(8191, 0, "R6 largest time exponent 6");
    readback("R3 readback full ring");

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule